// File: doc/BRIEF.md
# Programmable delay pipeline register

This block is a synchronous delay line for byte-wide data. Each word is captured on a rising clock edge and comes out unchanged after a run-time selectable number of cycles. A 4-bit length code chooses that latency. The code is itself registered, so a new value steers the output only from the edge that captures it. The delay is built from a full chain of stages with a tap selected at the output. Because of this, shortening or lengthening the delay never disturbs words already in flight. The output simply starts reading a different stage.

A build-time parameter chooses one of two variants. The short variant maps code n to n+1 cycles, covering 1 to 16 cycles. The long variant maps code n to n+3 cycles, covering 3 to 18 cycles. The long variant also honours a split input. When split is set, the low nibble keeps the programmed latency and the high nibble is pinned to the deepest stage, which is 18 cycles. The split input is registered alongside the length code. A synchronous active-high reset empties the chain.

Top module: `prog_delay_line`

## Requirements
- R1: Every output word equals the input word captured the selected number of cycles earlier, with all bits unchanged.
- R2: With the short variant (LONG_MODE=0), length code n gives a latency of n+1 cycles: code 0 gives 1 and code 15 gives 16.
- R3: With the long variant (LONG_MODE=1), length code n gives a latency of n+3 cycles: code 0 gives 3 and code 15 gives 18.
- R4: With the long variant and the split input low, both nibbles (bits 7..4 and 3..0) use the programmed latency.
- R5: With the long variant and the split input high, bits 3..0 use the programmed latency and bits 7..4 use 18 cycles whatever the code.
- R6: The length code is captured on a clock edge and selects the output tap from that edge onward. A code change in mid-stream reads the stored history at the new depth and loses no word held in the chain.
- R7: The split input is captured on the same edge as the length code, with the same one-cycle latency.
- R8: A synchronous active-high reset clears every stage and the captured code and split state to zero. The output then reads zero until valid data has travelled the selected depth.
- R9: In the short variant the split input has no effect on the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| din | input | DATA_W (8) | Data word entering the chain |
| len_code | input | CODE_W (4) | Latency select code, registered |
| split_mode | input | 1 | Nibble split request, registered; used by the long variant only |
| dout | output | DATA_W (8) | Delayed data word |

## Verification
The bench builds two copies that share one stimulus stream. The first is the default long variant with split support (LONG_MODE=1). The second is the short variant (LONG_MODE=0). Driving both copies together covers both code-to-latency maps across all sixteen codes. The same stimulus, with split high, exercises the split nibbles on the long copy and shows that split is ignored on the short copy. Length and split changes made while data is in flight are compared against a history of captured words, so a read from a wrong stage or a change taken one edge early or late shows up at the output.

// File: rtl/pdl_pkg.sv
package pdl_pkg;

    // Shortest latency offered by each variant.
    function automatic int min_latency(input bit long_variant);
        return long_variant ? 3 : 1;
    endfunction

    // Number of stages needed to reach the longest latency.
    function automatic int chain_depth(input bit long_variant, input int code_w);
        return min_latency(long_variant) + (1 << code_w) - 1;
    endfunction

endpackage

// File: rtl/pdl_ctrl.sv
module pdl_ctrl #(
    parameter int CODE_W   = 4,
    parameter bit SPLIT_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] code_i,
    input  logic              mode_i,
    output logic [CODE_W-1:0] code_o,
    output logic              split_o
);
    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              split;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;
    logic  split_req;

    // The split request only exists in the long variant.
    generate
        if (SPLIT_EN) begin : g_split
            assign split_req = mode_i;
        end else begin : g_whole
            assign split_req = 1'b0;
        end
    endgenerate

    always_comb begin
        ctrl_d       = ctrl_q;
        ctrl_d.code  = code_i;
        ctrl_d.split = split_req;
        if (rst) begin
            ctrl_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        ctrl_q <= ctrl_d;
    end

    assign code_o  = ctrl_q.code;
    assign split_o = ctrl_q.split;
endmodule

// File: rtl/pdl_stage_chain.sv
module pdl_stage_chain #(
    parameter int W     = 8,
    parameter int DEPTH = 18
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [W-1:0]              din_i,
    output logic [DEPTH-1:0][W-1:0]   taps_o
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] stg;
    } chain_t;

    chain_t chain_d, chain_q;

    // Every stage shifts each cycle; stage k holds the word captured k edges ago.
    always_comb begin
        chain_d        = chain_q;
        chain_d.stg[0] = din_i;
        for (int k = 1; k < DEPTH; k++) begin
            chain_d.stg[k] = chain_q.stg[k-1];
        end
        if (rst) begin
            chain_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        chain_q <= chain_d;
    end

    assign taps_o = chain_q.stg;
endmodule

// File: rtl/pdl_tap_select.sv
module pdl_tap_select #(
    parameter int W       = 8,
    parameter int DEPTH   = 18,
    parameter int CODE_W  = 4,
    parameter int MIN_LAT = 3
) (
    input  logic [DEPTH-1:0][W-1:0] taps_i,
    input  logic [CODE_W-1:0]       code_i,
    input  logic                    split_i,
    output logic [W-1:0]            dout_o
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int LO_W  = W / 2;
    localparam int HI_W  = W - LO_W;

    logic [IDX_W-1:0] sel;
    logic [W-1:0]     prog_word;
    logic [HI_W-1:0]  deep_hi;

    // Stage index = latency - 1, so the offset is MIN_LAT - 1.
    always_comb begin
        sel       = IDX_W'(MIN_LAT - 1) + IDX_W'(code_i);
        prog_word = taps_i[sel];
        deep_hi   = taps_i[DEPTH-1][W-1:LO_W];
        dout_o    = {(split_i ? deep_hi : prog_word[W-1:LO_W]), prog_word[LO_W-1:0]};
    end
endmodule

// File: rtl/prog_delay_line.sv
module prog_delay_line #(
    parameter int DATA_W    = 8,
    parameter int CODE_W    = 4,
    parameter bit LONG_MODE = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] din,
    input  logic [CODE_W-1:0] len_code,
    input  logic              split_mode,
    output logic [DATA_W-1:0] dout
);
    localparam int MIN_LAT = pdl_pkg::min_latency(LONG_MODE);
    localparam int DEPTH   = pdl_pkg::chain_depth(LONG_MODE, CODE_W);

    logic [CODE_W-1:0]            code_q;
    logic                         split_q;
    logic [DEPTH-1:0][DATA_W-1:0] taps;

    pdl_ctrl #(
        .CODE_W  (CODE_W),
        .SPLIT_EN(LONG_MODE)
    ) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .code_i (len_code),
        .mode_i (split_mode),
        .code_o (code_q),
        .split_o(split_q)
    );

    pdl_stage_chain #(
        .W    (DATA_W),
        .DEPTH(DEPTH)
    ) u_chain (
        .clk   (clk),
        .rst   (rst),
        .din_i (din),
        .taps_o(taps)
    );

    pdl_tap_select #(
        .W      (DATA_W),
        .DEPTH  (DEPTH),
        .CODE_W (CODE_W),
        .MIN_LAT(MIN_LAT)
    ) u_sel (
        .taps_i (taps),
        .code_i (code_q),
        .split_i(split_q),
        .dout_o (dout)
    );
endmodule

// File: rtl/pdl_chk.sv
module pdl_chk #(
    parameter int DATA_W    = 8,
    parameter int CODE_W    = 4,
    parameter bit LONG_MODE = 1'b1
) (
    input logic              clk,
    input logic              rst,
    input logic [DATA_W-1:0] din,
    input logic [CODE_W-1:0] len_code,
    input logic              split_mode,
    input logic [DATA_W-1:0] dout
);
    localparam int MIN_LAT = pdl_pkg::min_latency(LONG_MODE);
    localparam int DEPTH   = pdl_pkg::chain_depth(LONG_MODE, CODE_W);
    localparam int CW      = $clog2(DEPTH + 1) + 1;
    localparam int LO_W    = DATA_W / 2;

    logic [CW-1:0]     since_q;
    logic [CW-1:0]     run_q;
    logic [DATA_W-1:0] last_q;
    logic [LO_W-1:0]   din_lo;

    assign din_lo = din[LO_W-1:0];

    // Edges since reset, and length of the current run of identical inputs.
    always_ff @(posedge clk) begin
        last_q <= din;
        if (rst) begin
            since_q <= '0;
            run_q   <= '0;
        end else begin
            if (since_q < CW'(DEPTH)) since_q <= since_q + 1'b1;
            if (run_q == '0 || din != last_q) run_q <= CW'(1);
            else if (run_q < CW'(DEPTH)) run_q <= run_q + 1'b1;
        end
    end

    // R8
    warmup_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (since_q < CW'(MIN_LAT)) |-> (dout == '0));

    // R1
    steady_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (run_q >= CW'(DEPTH)) |-> (dout == last_q));

    generate
        if (LONG_MODE) begin : g_long
            // R3
            long_min_lat_chk: assert property (@(posedge clk) disable iff (rst)
                ($past(len_code) == '0 && !$past(split_mode) && since_q >= CW'(3))
                |-> (dout == $past(din, 3)));

            // R5
            split_low_chk: assert property (@(posedge clk) disable iff (rst)
                ($past(len_code) == '0 && $past(split_mode) && since_q >= CW'(3))
                |-> (dout[LO_W-1:0] == $past(din_lo, 3)));
        end else begin : g_short
            // R2
            short_min_lat_chk: assert property (@(posedge clk) disable iff (rst)
                (len_code == '0) |=> (dout == $past(din)));
        end
    endgenerate
endmodule

bind prog_delay_line pdl_chk #(
    .DATA_W   (DATA_W),
    .CODE_W   (CODE_W),
    .LONG_MODE(LONG_MODE)
) u_pdl_chk (
    .clk       (clk),
    .rst       (rst),
    .din       (din),
    .len_code  (len_code),
    .split_mode(split_mode),
    .dout      (dout)
);

// File: tb/sim_prog_delay_line.sv
module sim_prog_delay_line;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] din = 8'h00;
    logic [3:0] len_code = 4'd0;
    logic       split_mode = 1'b0;
    logic [7:0] dout_long, dout_short;

    int n_checks = 0;
    int n_fail   = 0;
    int seq      = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    prog_delay_line #(.DATA_W(8), .CODE_W(4), .LONG_MODE(1'b1)) u0 (
        .clk(clk), .rst(rst), .din(din), .len_code(len_code),
        .split_mode(split_mode), .dout(dout_long)
    );

    prog_delay_line #(.DATA_W(8), .CODE_W(4), .LONG_MODE(1'b0)) u1 (
        .clk(clk), .rst(rst), .din(din), .len_code(len_code),
        .split_mode(split_mode), .dout(dout_short)
    );

    // Reference: history of captured words plus captured code and split.
    logic [7:0] hist [64];
    int         cnt = 0;
    logic [3:0] code_m = 4'd0;
    logic       split_m = 1'b0;

    always @(posedge clk) begin
        if (rst) begin
            cnt     <= 0;
            code_m  <= 4'd0;
            split_m <= 1'b0;
        end else begin
            hist[cnt % 64] <= din;
            cnt     <= cnt + 1;
            code_m  <= len_code;
            split_m <= split_mode;
        end
    end

    function automatic logic [7:0] tapv(input int lat);
        int idx = cnt - lat;
        if (idx < 0) return 8'h00;
        return hist[idx % 64];
    endfunction

    function automatic logic [7:0] expect_out(input bit long_v);
        int         lat = (long_v ? 3 : 1) + int'(code_m);
        logic [7:0] lo  = tapv(lat);
        logic [7:0] hi  = (long_v && split_m) ? tapv(18) : lo;
        return {hi[7:4], lo[3:0]};
    endfunction

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h at t=%0t", req, got, exp, $time);
        end
    endtask

    // One cycle: new word in, edge, then compare both copies at the falling edge.
    task automatic step(input string req_long, input string req_short);
        din = 8'((seq * 73 + 29) ^ (seq >> 3));
        seq++;
        @(posedge clk);
        @(negedge clk);
        if (req_long != "")  check(req_long,  dout_long,  expect_out(1'b1));
        if (req_short != "") check(req_short, dout_short, expect_out(1'b0));
    endtask

    task automatic t_reset();
        rst = 1'b1;
        len_code = 4'd9;
        for (int i = 0; i < 3; i++) begin
            din = 8'hA5 + 8'(i);
            @(posedge clk);
            @(negedge clk);
            check("R8 reset long", dout_long, 8'h00);
            check("R8 reset short", dout_short, 8'h00);
        end
        rst = 1'b0;
        len_code = 4'd15;
        for (int i = 0; i < 20; i++) step("R8 warmup long", "R8 warmup short");
    endtask

    task automatic t_sweep();
        split_mode = 1'b0;
        for (int c = 0; c < 16; c++) begin
            len_code = 4'(c);
            for (int i = 0; i < 20; i++) step("R3 R4 long sweep", "R2 short sweep");
        end
    endtask

    task automatic t_pattern();
        logic [7:0] pats [12] = '{8'hFF, 8'h00, 8'hA5, 8'h5A, 8'h01, 8'h02,
                                  8'h04, 8'h08, 8'h10, 8'h20, 8'h40, 8'h80};
        len_code = 4'd5;
        split_mode = 1'b0;
        for (int i = 0; i < 36; i++) begin
            din = pats[i % 12];
            @(posedge clk);
            @(negedge clk);
            check("R1 pattern long", dout_long, expect_out(1'b1));
            check("R1 pattern short", dout_short, expect_out(1'b0));
        end
    endtask

    task automatic t_split();
        split_mode = 1'b1;
        len_code = 4'd0;
        for (int i = 0; i < 25; i++) step("R5 split code0", "R9 split ignored");
        len_code = 4'd9;
        for (int i = 0; i < 25; i++) step("R5 split code9", "R9 split ignored");
        len_code = 4'd15;
        for (int i = 0; i < 25; i++) step("R5 split code15", "R9 split ignored");
        split_mode = 1'b0;
    endtask

    task automatic t_change();
        logic [3:0] codes [8] = '{4'd0, 4'd15, 4'd3, 4'd12, 4'd7, 4'd1, 4'd14, 4'd6};
        split_mode = 1'b0;
        for (int r = 0; r < 3; r++) begin
            for (int j = 0; j < 8; j++) begin
                len_code = codes[j];
                for (int i = 0; i < 3; i++) step("R6 change long", "R6 change short");
            end
        end
    endtask

    task automatic t_mode_toggle();
        len_code = 4'd4;
        for (int r = 0; r < 12; r++) begin
            split_mode = r[0];
            for (int i = 0; i < 5; i++) step("R7 split toggle", "R9 toggle ignored");
        end
        split_mode = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_sweep();
        t_pattern();
        t_split();
        t_change();
        t_mode_toggle();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule